// File: doc/BRIEF.md
# Status Register Masked Write Unit

This block holds the processor's live status word and one saved copy of it, and carries out the two instructions that move data between them and the general datapath. For a write, it decodes the instruction to find the source operand, which register is targeted and which byte lanes may change. It then merges the new value under that lane mask and applies the privilege rules. If the low mode field of the live word is rewritten, it raises a one-cycle strobe that carries the previous and the next mode. Register banking itself happens elsewhere and is driven from that strobe. For a read, it returns the status register that the instruction selects.

The operand register is chosen by the instruction itself. The block drives the register index out combinationally and takes the register-file value back in the same cycle. Updates take effect on the clock edge at which a valid write is presented. Reads are combinational from the current register contents.

Top module: `psr_xfer_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `cpsr` equals the reset value 0x000000D3 (mode 0x13, bits 7 and 6 set), `spsr` is zero, and `mode_chg` and `priv_err` are low.
- R2: With instruction bit 25 at 1, the write operand is instruction bits 7:0, zero-extended to 32 bits and rotated right by twice the value in bits 11:8.
- R3: With instruction bit 25 at 0, the write operand is `src_data`. In every cycle, `src_idx` equals instruction bits 3:0.
- R4: Instruction bits 16, 17, 18 and 19 enable byte lanes 7:0, 15:8, 23:16 and 31:24 respectively. A write to the live register (bit 22 = 0) produces (old AND NOT mask) OR (operand AND mask).
- R5: While the mode field `cpsr[4:0]` equals 0x10 (user), a live-register write can change only bits 31:28, whatever lanes are enabled.
- R6: In user mode, a write with bit 22 = 1 (saved register) pulses `priv_err` for one cycle and leaves both registers unchanged.
- R7: Outside user mode, a write with bit 22 = 1 loads the whole operand into `spsr` and ignores the lane enables.
- R8: When a live-register write changes `cpsr[4:0]`, `mode_chg` is high for the next cycle, with `mode_old` holding the previous field and `mode_new` the new one. Otherwise `mode_chg` is low.
- R9: With `insn_write` low, `rd_data` returns `spsr` when bit 22 is 1 and `cpsr` when it is 0.
- R10: A cycle without a valid write (`insn_valid` low, or a read) changes neither register and leaves `mode_chg` and `priv_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_write | input | 1 | 1 = move into a status register, 0 = read one |
| insn_word | input | 32 | Instruction word |
| src_idx | output | 4 | Register-file index of the operand |
| src_data | input | 32 | Register-file value for `src_idx` |
| rd_data | output | 32 | Selected status register for reads |
| cpsr | output | 32 | Live status register |
| spsr | output | 32 | Saved status register |
| mode_chg | output | 1 | One-cycle strobe: mode field rewritten |
| mode_old | output | 5 | Mode before the change |
| mode_new | output | 5 | Mode after the change |
| priv_err | output | 1 | One-cycle strobe: illegal user-mode saved-register write |

## Verification
Two behaviours can fall in the same cycle: the user-mode flag restriction and the mode-change strobe. A user-mode live write that enables the low lane with a different mode value would change the mode if the restriction failed. The bench provokes this both directly and through random operands whose mode field is drawn from a small set that often holds the user code. It then judges the result by checking that `mode_chg` stays low and that bits 27:0 are preserved. Random reg-operand writes in privileged modes also rewrite flags and mode together, and the bench compares the merged word and the strobe's old and new fields against its own model in the same check cycle.

// File: rtl/psr_xfer_pkg.sv
`timescale 1ns/1ps
// Shared types for the status register transfer unit.
// Assumes a 32-bit instruction word with fixed field positions.
package psr_xfer_pkg;

    typedef enum logic [0:0] {
        TGT_LIVE  = 1'b0,
        TGT_SAVED = 1'b1
    } psr_target_e;

    typedef struct packed {
        logic        use_imm;
        psr_target_e target;
        logic [3:0]  lane_en;
        logic [3:0]  rot_half;
        logic [7:0]  imm8;
        logic [3:0]  reg_idx;
    } psr_fields_t;

    // Pull the fields used by the transfer path out of an instruction word.
    function automatic psr_fields_t psr_decode(input logic [31:0] w);
        psr_fields_t f;
        f.use_imm  = w[25];
        f.target   = psr_target_e'(w[22]);
        f.lane_en  = w[19:16];
        f.rot_half = w[11:8];
        f.imm8     = w[7:0];
        f.reg_idx  = w[3:0];
        return f;
    endfunction

endpackage

// File: rtl/psr_operand.sv
`timescale 1ns/1ps
// Selects the write operand: either a rotated 8-bit immediate or the
// register-file value. Assumes WORD_W is at least 8 and ROT_W small.
module psr_operand #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ROT_W  = 4
) (
    input  logic              use_imm,
    input  logic [7:0]        imm8,
    input  logic [ROT_W-1:0]  rot_half,
    input  logic [WORD_W-1:0] reg_val,
    output logic [WORD_W-1:0] operand
);
    localparam int unsigned AMT_W = ROT_W + 1;

    logic [2*WORD_W-1:0] doubled;
    logic [2*WORD_W-1:0] shifted;
    logic [AMT_W-1:0]    amount;

    // Rotate by shifting a doubled copy; the low half is the rotated word.
    always_comb begin
        amount  = {rot_half, 1'b0};
        doubled = {{(WORD_W-8){1'b0}}, imm8, {(WORD_W-8){1'b0}}, imm8};
        shifted = doubled >> amount;
        operand = use_imm ? shifted[WORD_W-1:0] : reg_val;
    end
endmodule

// File: rtl/psr_lane_mask.sv
`timescale 1ns/1ps
// Expands per-lane enables into a bit mask, one byte per enable.
module psr_lane_mask #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] mask
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Replicate each enable across its byte.
        assign mask[i*LANE_W +: LANE_W] = {LANE_W{lane_en[i]}};
    end
endmodule

// File: rtl/psr_merge.sv
`timescale 1ns/1ps
// Computes next register values and write enables under privilege rules.
// Assumes the mode field sits in the low MODE_W bits and flags on top.
module psr_merge #(
    parameter int unsigned          WORD_W    = 32,
    parameter int unsigned          MODE_W    = 5,
    parameter int unsigned          FLAG_BITS = 4,
    parameter logic [MODE_W-1:0]    USER_MODE = 5'h10
) (
    input  logic              wr_req,
    input  logic              to_saved,
    input  logic [WORD_W-1:0] live_q,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] lane_mask,
    output logic [WORD_W-1:0] live_d,
    output logic              live_we,
    output logic              saved_we,
    output logic              illegal,
    output logic              mode_moved
);
    localparam logic [WORD_W-1:0] FLAG_MASK =
        {{FLAG_BITS{1'b1}}, {(WORD_W-FLAG_BITS){1'b0}}};

    logic              in_user;
    logic [WORD_W-1:0] eff_mask;

    // Narrow the mask in user mode and form the merged live word.
    always_comb begin
        in_user    = (live_q[MODE_W-1:0] == USER_MODE);
        eff_mask   = in_user ? (lane_mask & FLAG_MASK) : lane_mask;
        live_d     = (live_q & ~eff_mask) | (operand & eff_mask);
        live_we    = wr_req && !to_saved;
        saved_we   = wr_req && to_saved && !in_user;
        illegal    = wr_req && to_saved && in_user;
        mode_moved = live_we && (live_d[MODE_W-1:0] != live_q[MODE_W-1:0]);
    end
endmodule

// File: rtl/psr_xfer_unit.sv
`timescale 1ns/1ps
// Status register transfer unit: holds live and saved status words,
// performs masked writes and reads, reports mode changes and illegal
// user-mode saved-register writes. Banking is done by the consumer.
module psr_xfer_unit
    import psr_xfer_pkg::*;
#(
    parameter logic [31:0] RESET_PSR = 32'h0000_00D3,
    parameter logic [4:0]  USER_MODE = 5'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_valid,
    input  logic        insn_write,
    input  logic [31:0] insn_word,
    output logic [3:0]  src_idx,
    input  logic [31:0] src_data,
    output logic [31:0] rd_data,
    output logic [31:0] cpsr,
    output logic [31:0] spsr,
    output logic        mode_chg,
    output logic [4:0]  mode_old,
    output logic [4:0]  mode_new,
    output logic        priv_err
);
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = WORD_W / LANE_W;
    localparam int unsigned MODE_W = 5;

    psr_fields_t       fld;
    logic [WORD_W-1:0] operand, mask, live_d;
    logic              live_we, saved_we, illegal, mode_moved;
    logic [WORD_W-1:0] cpsr_q, spsr_q;
    logic              chg_q, err_q;
    logic [MODE_W-1:0] old_q, new_q;

    // Decode the instruction fields once for all sub-blocks.
    always_comb fld = psr_decode(insn_word);

    psr_operand #(.WORD_W(WORD_W), .ROT_W(4)) u_operand (
        .use_imm  (fld.use_imm),
        .imm8     (fld.imm8),
        .rot_half (fld.rot_half),
        .reg_val  (src_data),
        .operand  (operand)
    );

    psr_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
        .lane_en (fld.lane_en),
        .mask    (mask)
    );

    psr_merge #(
        .WORD_W(WORD_W), .MODE_W(MODE_W), .FLAG_BITS(4), .USER_MODE(USER_MODE)
    ) u_merge (
        .wr_req     (insn_valid && insn_write),
        .to_saved   (fld.target == TGT_SAVED),
        .live_q     (cpsr_q),
        .operand    (operand),
        .lane_mask  (mask),
        .live_d     (live_d),
        .live_we    (live_we),
        .saved_we   (saved_we),
        .illegal    (illegal),
        .mode_moved (mode_moved)
    );

    // Register state and the one-cycle event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q <= RESET_PSR;
            spsr_q <= '0;
            chg_q  <= 1'b0;
            err_q  <= 1'b0;
            old_q  <= '0;
            new_q  <= '0;
        end else begin
            if (live_we)  cpsr_q <= live_d;
            if (saved_we) spsr_q <= operand;
            chg_q <= mode_moved;
            err_q <= illegal;
            if (mode_moved) begin
                old_q <= cpsr_q[MODE_W-1:0];
                new_q <= live_d[MODE_W-1:0];
            end
        end
    end

    // Outputs and the combinational read path.
    always_comb begin
        src_idx  = fld.reg_idx;
        rd_data  = (fld.target == TGT_SAVED) ? spsr_q : cpsr_q;
        cpsr     = cpsr_q;
        spsr     = spsr_q;
        mode_chg = chg_q;
        mode_old = old_q;
        mode_new = new_q;
        priv_err = err_q;
    end
endmodule

// File: rtl/psr_xfer_chk.sv
`timescale 1ns/1ps
// Property checker for psr_xfer_unit, attached by bind below.
module psr_xfer_chk #(
    parameter logic [31:0] RESET_PSR = 32'h0000_00D3,
    parameter logic [4:0]  USER_MODE = 5'h10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic        insn_write,
    input logic [31:0] insn_word,
    input logic [31:0] cpsr,
    input logic [31:0] spsr,
    input logic        mode_chg,
    input logic [4:0]  mode_old,
    input logic [4:0]  mode_new,
    input logic        priv_err
);
    logic user_now, wr_now;
    always_comb begin
        user_now = (cpsr[4:0] == USER_MODE);
        wr_now   = insn_valid && insn_write;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cpsr == RESET_PSR && spsr == 32'h0 && !mode_chg && !priv_err));

    a_r5_user_flags_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && user_now && !insn_word[22]) |=> (cpsr[27:0] == $past(cpsr[27:0])));

    a_r6_user_saved_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && user_now && insn_word[22]) |=> (priv_err && $stable(cpsr) && $stable(spsr)));

    a_r8_strobe_fields: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (mode_old != mode_new && mode_new == cpsr[4:0]));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_now |=> ($stable(cpsr) && $stable(spsr) && !mode_chg && !priv_err));
endmodule

bind psr_xfer_unit psr_xfer_chk #(.RESET_PSR(RESET_PSR), .USER_MODE(USER_MODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_write (insn_write),
    .insn_word  (insn_word),
    .cpsr       (cpsr),
    .spsr       (spsr),
    .mode_chg   (mode_chg),
    .mode_old   (mode_old),
    .mode_new   (mode_new),
    .priv_err   (priv_err)
);

// File: tb/psr_xfer_unit_bench.sv
`timescale 1ns/1ps
// Directed plus seeded random bench for psr_xfer_unit.
module psr_xfer_unit_bench;
    localparam logic [31:0] RST_PSR = 32'h0000_00D3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic        insn_write = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] src_data = '0;
    logic [3:0]  src_idx;
    logic [31:0] rd_data, cpsr, spsr;
    logic        mode_chg, priv_err;
    logic [4:0]  mode_old, mode_new;

    int nvec = 0;
    int nbad = 0;
    logic [31:0] m_cpsr, m_spsr;

    psr_xfer_unit u_psr_xfer_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_write(insn_write),
        .insn_word(insn_word), .src_idx(src_idx), .src_data(src_data),
        .rd_data(rd_data), .cpsr(cpsr), .spsr(spsr), .mode_chg(mode_chg),
        .mode_old(mode_old), .mode_new(mode_new), .priv_err(priv_err)
    );

    initial forever #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_operand(input logic [31:0] w, input logic [31:0] sd);
        logic [31:0] v;
        int amt;
        if (!w[25]) return sd;
        v   = {24'h0, w[7:0]};
        amt = 2 * int'(w[11:8]);
        if (amt == 0) return v;
        return (v >> amt) | (v << (32 - amt));
    endfunction

    function automatic logic [31:0] exp_mask(input logic [31:0] w);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (w[16+i]) m |= 32'hFF << (8*i);
        return m;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; insn_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cpsr = RST_PSR; m_spsr = '0;
        chk(cpsr == RST_PSR, "R1 cpsr reset", cpsr, RST_PSR);
        chk(spsr == 32'h0, "R1 spsr reset", spsr, 32'h0);
        chk(!mode_chg && !priv_err, "R1 strobes low", {30'h0, mode_chg, priv_err}, 32'h0);
    endtask

    // Called at a negedge; applies one cycle of stimulus and checks results.
    task automatic do_op(input logic [31:0] w, input bit wr, input logic [31:0] sd, input bit vld);
        logic [31:0] v, m, nc;
        bit user, e_err, e_chg;
        logic [4:0] old_m;
        insn_word = w; insn_write = wr; src_data = sd; insn_valid = vld;
        #1;
        chk(src_idx == w[3:0], "R3 src_idx", {28'h0, src_idx}, {28'h0, w[3:0]});
        if (!wr) chk(rd_data == (w[22] ? m_spsr : m_cpsr), "R9 read data", rd_data,
                     w[22] ? m_spsr : m_cpsr);
        e_err = 0; e_chg = 0; old_m = m_cpsr[4:0];
        if (vld && wr) begin
            v = exp_operand(w, sd);
            m = exp_mask(w);
            user = (m_cpsr[4:0] == 5'h10);
            if (w[22]) begin
                if (user) e_err = 1; else m_spsr = v;
            end else begin
                if (user) m &= 32'hF000_0000;
                nc = (m_cpsr & ~m) | (v & m);
                e_chg = (nc[4:0] != old_m);
                m_cpsr = nc;
            end
        end
        @(negedge clk);
        insn_valid = 1'b0;
        chk(cpsr == m_cpsr, w[25] ? "R2 cpsr imm" : "R4 cpsr merge", cpsr, m_cpsr);
        chk(spsr == m_spsr, "R7 spsr", spsr, m_spsr);
        chk(priv_err == e_err, "R6 priv_err", {31'h0, priv_err}, {31'h0, e_err});
        chk(mode_chg == e_chg, "R8 mode_chg", {31'h0, mode_chg}, {31'h0, e_chg});
        if (e_chg)
            chk(mode_old == old_m && mode_new == m_cpsr[4:0], "R8 old/new",
                {22'h0, mode_old, mode_new}, {22'h0, old_m, m_cpsr[4:0]});
    endtask

    function automatic logic [4:0] pick_mode();
        case ($urandom_range(0, 5))
            0, 1:    return 5'h10;
            2:       return 5'h11;
            3:       return 5'h12;
            4:       return 5'h13;
            default: return 5'h1F;
        endcase
    endfunction

    initial begin
        bit done_ok;
        done_ok = 0;
        void'($urandom(32'd2718));
        fork
            begin
                do_reset();
                // R2: imm 0xF0 rotated right by 8 into flag lane only -> 0xF0000000 flags.
                do_op(32'h0208_04F0, 1, 32'h0, 1);
                chk(cpsr == 32'hF000_00D3, "R2 rotate", cpsr, 32'hF000_00D3);
                // R7: privileged saved write, only lane 0 enabled, whole word loads.
                do_op(32'h0041_0005, 1, 32'h1234_5678, 1);
                chk(spsr == 32'h1234_5678, "R7 full load", spsr, 32'h1234_5678);
                // R9: read saved, then live.
                do_op(32'h0040_0000, 0, 32'h0, 1);
                do_op(32'h0000_0000, 0, 32'h0, 1);
                // R4: lanes 1 and 2 from register.
                do_op(32'h0006_0002, 1, 32'hAABB_CCDD, 1);
                chk(cpsr == 32'hF0BB_CCD3, "R4 lanes", cpsr, 32'hF0BB_CCD3);
                // R8: enter user mode through lane 0.
                do_op(32'h0001_0003, 1, 32'h0000_0010, 1);
                chk(mode_chg && mode_new == 5'h10, "R8 to user", {27'h0, mode_new}, 32'h10);
                // R5: user full-mask write with a new mode value; only flags change.
                do_op(32'h000F_0001, 1, 32'h5FFF_FF13, 1);
                chk(cpsr == 32'h50BB_CC10, "R5 user flags", cpsr, 32'h50BB_CC10);
                // R6: user saved write is rejected.
                do_op(32'h004F_0001, 1, 32'hDEAD_BEEF, 1);
                // R10: invalid write cycle changes nothing.
                do_op(32'h000F_0001, 1, 32'hFFFF_FFFF, 0);
                do_reset();
                for (int n = 0; n < 800; n++) begin
                    logic [31:0] w, sd;
                    if (n % 64 == 63) do_reset();
                    w = $urandom;
                    sd = $urandom;
                    sd[4:0] = pick_mode();
                    if (w[25] && ($urandom_range(0, 1) == 0)) w[7:0] = {3'b000, pick_mode()};
                    if (w[25]) w[11:8] = ($urandom_range(0, 2) == 0) ? 4'h0 : w[11:8];
                    do_op(w, ($urandom_range(0, 9) < 7), sd, ($urandom_range(0, 9) != 0));
                end
                done_ok = 1;
            end
            begin
                repeat (150000) @(posedge clk);
                nvec++; nbad++;
                $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            end
        join_any
        disable fork;
        if (!done_ok) $display("bench stopped early");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule